// File: doc/BRIEF.md
# Overloaded Command Dispatch Unit

This unit executes a small set of overloadable register-to-register commands. Each command carries a command index `k`, a first operand whose low 12 bits name a logical unit, a second operand, the one-hot privilege level of the issuing context and a debug-mode flag. The meaning of the command is fixed at run time by looking up the pair (logical unit, privilege) in a routing table. The table yields a target device port and a 12-bit sub-unit code. A hit forwards the request to that device over a valid/ready channel and waits for its response. Some logical units are served inside the unit itself: one always traps, one always returns zero and one always returns all ones.

The routing table is loaded through a simple write port, normally during boot. Every command ends in exactly one way: a register result, a trap request naming the privilege level that must handle it, a debug exception, or a silent retire. Only one command is in flight at a time. The issuing pipeline sees `cmd_ready` low from acceptance until completion.

Privilege encoding on `cmd_priv` and `trap_target`: user 4'b0001, supervisor 4'b0010, hypervisor 4'b0100, machine 4'b1000.

Top module: `ovl_dispatch`

## Requirements
- R1: After reset `cmd_ready` is 1. `rd_valid`, `trap_valid`, `dbg_exc`, `cmd_done` and `dev_req_valid` are 0, and every routing entry is invalid.
- R2: Logical unit 1 completes with `rd_data` = 0 for every `k` and privilege. It sends no device request, even when a table entry names unit 1. The result pulse appears on the second rising edge after acceptance.
- R3: Logical unit 2 completes with `rd_data` = all ones for every `k` and privilege. It sends no device request, with the same timing as R2.
- R4: Unit 0, the reserved units 3..31 (even with a matching table entry) and any (unit, privilege) pair with no matching entry all end in a fault. From user, supervisor or hypervisor level the fault raises `trap_valid` with `trap_target` = the issuing level shifted up one bit position.
- R5: A fault at machine level raises no trap. It pulses `dbg_exc` when `cmd_dbg` was 1 at acceptance. Otherwise it only pulses `cmd_done`.
- R6: An entry matches when it is valid, its unit equals operand-1 bits 11:0 and its privilege mask has the issuing level's bit set. Bits above 11 of operand 1 take no part in the match. When several entries match, the lowest index wins.
- R7: A routed command raises `dev_req_valid` on the second rising edge after acceptance. It carries `dev_req_sel` = the entry's device, `dev_req_code` = {k, sub-unit code} (sub-unit code in bits 11:0, k from bit 12), and both operands unchanged. The request is held stable until `dev_req_ready`, and it drops on the edge that accepts it.
- R8: `cmd_ready` is 0 from the edge that accepts a command until the edge that produces its completion pulse. It is 1 again in the cycle of that pulse.
- R9: A device response with `dev_rsp_err` = 0 yields `rd_valid` with `rd_data` = `dev_rsp_data` one edge after the response. With `dev_rsp_err` = 1 it is handled as a fault under R4/R5 instead.
- R10: Each command produces exactly one single-cycle `cmd_done` pulse. At most one of `rd_valid`, `trap_valid` and `dbg_exc` is high, and only together with `cmd_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tbl_we | input | 1 | Routing table write strobe |
| tbl_idx | input | IDXW | Entry index to write |
| tbl_valid | input | 1 | Valid bit for the written entry |
| tbl_lun | input | 12 | Logical unit of the entry |
| tbl_pmask | input | 4 | Privilege levels the entry applies to |
| tbl_dev | input | DEVW | Target device port |
| tbl_sub | input | 12 | Sub-unit code sent to the device |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Unit idle, command accepted when valid |
| cmd_k | input | KW | Command index |
| cmd_rs1 | input | XLEN | Operand 1, logical unit in bits 11:0 |
| cmd_rs2 | input | XLEN | Operand 2 |
| cmd_priv | input | 4 | One-hot issuing privilege |
| cmd_dbg | input | 1 | Debug mode active |
| dev_req_valid | output | 1 | Device request valid |
| dev_req_ready | input | 1 | Device accepts request |
| dev_req_sel | output | DEVW | Device port selected |
| dev_req_code | output | 12+KW | {k, sub-unit code} |
| dev_req_rs1 | output | XLEN | Forwarded operand 1 |
| dev_req_rs2 | output | XLEN | Forwarded operand 2 |
| dev_rsp_valid | input | 1 | Device response valid |
| dev_rsp_data | input | XLEN | Device result |
| dev_rsp_err | input | 1 | Device reports configuration error |
| rd_valid | output | 1 | Register result pulse |
| rd_data | output | XLEN | Register result |
| trap_valid | output | 1 | Trap request pulse |
| trap_target | output | 4 | One-hot privilege that takes the trap |
| dbg_exc | output | 1 | Debug exception pulse |
| cmd_done | output | 1 | Command completion pulse |

## Verification
A corrupted routing entry or lookup shows as a wrong `dev_req_sel` or `dev_req_code` on the second edge after acceptance. It can also show as a device request where a fault or built-in result was due, and the reverse. A control state stuck or skipped shows as `cmd_ready` at the wrong level, or as a completion pulse that is missing, doubled or mistimed. The bench compares every cycle, so the error is reported on the first clock it reaches a port. Wrong fault routing shows in the cycle of the completion pulse, as the wrong choice among trap, debug exception and silent retire, or as the wrong target level.

// File: rtl/ovl_pkg.sv
package ovl_pkg;
  localparam int LUN_W  = 12;
  localparam int SUB_W  = 12;
  localparam int PRIV_W = 4;

  localparam logic [LUN_W-1:0] LUN_FAULT    = 12'd0;
  localparam logic [LUN_W-1:0] LUN_ZERO     = 12'd1;
  localparam logic [LUN_W-1:0] LUN_ONES     = 12'd2;
  localparam logic [LUN_W-1:0] LUN_RSV_LAST = 12'd31;

  localparam logic [PRIV_W-1:0] PRIV_MACH = 4'b1000;

  typedef enum logic [1:0] {CL_FAULT, CL_ZERO, CL_ONES, CL_ROUTE} cls_e;
  typedef enum logic [1:0] {ST_IDLE, ST_LOOK, ST_REQ, ST_WAIT} st_e;
endpackage

// File: rtl/ovl_route_table.sv
module ovl_route_table
  import ovl_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int DEVW  = 2,
  localparam int IDXW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [IDXW-1:0]   wr_idx,
  input  logic              wr_valid,
  input  logic [LUN_W-1:0]  wr_lun,
  input  logic [PRIV_W-1:0] wr_pmask,
  input  logic [DEVW-1:0]   wr_dev,
  input  logic [SUB_W-1:0]  wr_sub,
  input  logic [LUN_W-1:0]  q_lun,
  input  logic [PRIV_W-1:0] q_priv,
  output logic              hit,
  output logic [DEVW-1:0]   hit_dev,
  output logic [SUB_W-1:0]  hit_sub
);
  logic [DEPTH-1:0]  ent_v;
  logic [LUN_W-1:0]  ent_lun [DEPTH];
  logic [PRIV_W-1:0] ent_pm  [DEPTH];
  logic [DEVW-1:0]   ent_dev [DEPTH];
  logic [SUB_W-1:0]  ent_sub [DEPTH];
  logic [DEPTH-1:0]  match;

  always_ff @(posedge clk) begin
    if (rst) ent_v <= '0;
    else if (wr_en) ent_v[wr_idx] <= wr_valid;
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      ent_lun[wr_idx] <= wr_lun;
      ent_pm[wr_idx]  <= wr_pmask;
      ent_dev[wr_idx] <= wr_dev;
      ent_sub[wr_idx] <= wr_sub;
    end
  end

  for (genvar e = 0; e < DEPTH; e++) begin : g_cmp
    assign match[e] = ent_v[e] && (ent_lun[e] == q_lun) && (|(ent_pm[e] & q_priv));
  end

  always_comb begin
    hit     = 1'b0;
    hit_dev = '0;
    hit_sub = '0;
    for (int e = DEPTH - 1; e >= 0; e--) begin
      if (match[e]) begin
        hit     = 1'b1;
        hit_dev = ent_dev[e];
        hit_sub = ent_sub[e];
      end
    end
  end

  // R6
  hit_has_match_chk: assert property (@(posedge clk) disable iff (rst)
    hit |-> (match != '0));
endmodule

// File: rtl/ovl_classify.sv
module ovl_classify
  import ovl_pkg::*;
(
  input  logic [LUN_W-1:0] lun,
  input  logic             hit,
  output cls_e             cls
);
  always_comb begin
    if (lun == LUN_ZERO)          cls = CL_ZERO;
    else if (lun == LUN_ONES)     cls = CL_ONES;
    else if (lun <= LUN_RSV_LAST) cls = CL_FAULT;
    else if (hit)                 cls = CL_ROUTE;
    else                          cls = CL_FAULT;
  end
endmodule

// File: rtl/ovl_fault_sel.sv
module ovl_fault_sel
  import ovl_pkg::*;
(
  input  logic [PRIV_W-1:0] priv,
  output logic              at_mach,
  output logic [PRIV_W-1:0] target
);
  assign at_mach = (priv == PRIV_MACH);
  assign target  = {priv[PRIV_W-2:0], 1'b0};
endmodule

// File: rtl/ovl_dispatch.sv
module ovl_dispatch
  import ovl_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int DEPTH = 8,
  parameter int NDEV  = 4,
  parameter int NCMD  = 8,
  localparam int KW     = $clog2(NCMD),
  localparam int DEVW   = (NDEV > 1) ? $clog2(NDEV) : 1,
  localparam int IDXW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CODE_W = SUB_W + KW
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tbl_we,
  input  logic [IDXW-1:0]   tbl_idx,
  input  logic              tbl_valid,
  input  logic [LUN_W-1:0]  tbl_lun,
  input  logic [PRIV_W-1:0] tbl_pmask,
  input  logic [DEVW-1:0]   tbl_dev,
  input  logic [SUB_W-1:0]  tbl_sub,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [KW-1:0]     cmd_k,
  input  logic [XLEN-1:0]   cmd_rs1,
  input  logic [XLEN-1:0]   cmd_rs2,
  input  logic [PRIV_W-1:0] cmd_priv,
  input  logic              cmd_dbg,
  output logic              dev_req_valid,
  input  logic              dev_req_ready,
  output logic [DEVW-1:0]   dev_req_sel,
  output logic [CODE_W-1:0] dev_req_code,
  output logic [XLEN-1:0]   dev_req_rs1,
  output logic [XLEN-1:0]   dev_req_rs2,
  input  logic              dev_rsp_valid,
  input  logic [XLEN-1:0]   dev_rsp_data,
  input  logic              dev_rsp_err,
  output logic              rd_valid,
  output logic [XLEN-1:0]   rd_data,
  output logic              trap_valid,
  output logic [PRIV_W-1:0] trap_target,
  output logic              dbg_exc,
  output logic              cmd_done
);
  st_e               state;
  logic [KW-1:0]     q_k;
  logic [XLEN-1:0]   q_rs1, q_rs2;
  logic [PRIV_W-1:0] q_priv;
  logic              q_dbg;

  logic              hit;
  logic [DEVW-1:0]   hit_dev;
  logic [SUB_W-1:0]  hit_sub;
  cls_e              cls;
  logic              at_mach;
  logic [PRIV_W-1:0] flt_target;

  logic              fin_en, fin_fault, start_req;
  logic [XLEN-1:0]   fin_data;

  ovl_route_table #(.DEPTH(DEPTH), .DEVW(DEVW)) u_tbl (
    .clk(clk), .rst(rst),
    .wr_en(tbl_we), .wr_idx(tbl_idx), .wr_valid(tbl_valid), .wr_lun(tbl_lun),
    .wr_pmask(tbl_pmask), .wr_dev(tbl_dev), .wr_sub(tbl_sub),
    .q_lun(q_rs1[LUN_W-1:0]), .q_priv(q_priv),
    .hit(hit), .hit_dev(hit_dev), .hit_sub(hit_sub)
  );

  ovl_classify u_cls (.lun(q_rs1[LUN_W-1:0]), .hit(hit), .cls(cls));

  ovl_fault_sel u_flt (.priv(q_priv), .at_mach(at_mach), .target(flt_target));

  assign cmd_ready = (state == ST_IDLE);

  always_comb begin
    fin_en    = 1'b0;
    fin_fault = 1'b0;
    fin_data  = '0;
    start_req = 1'b0;
    case (state)
      ST_LOOK: begin
        case (cls)
          CL_ZERO:  fin_en = 1'b1;
          CL_ONES:  begin fin_en = 1'b1; fin_data = '1; end
          CL_ROUTE: start_req = 1'b1;
          default:  begin fin_en = 1'b1; fin_fault = 1'b1; end
        endcase
      end
      ST_WAIT: begin
        if (dev_rsp_valid) begin
          fin_en    = 1'b1;
          fin_fault = dev_rsp_err;
          fin_data  = dev_rsp_data;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state         <= ST_IDLE;
      q_k           <= '0;
      q_rs1         <= '0;
      q_rs2         <= '0;
      q_priv        <= '0;
      q_dbg         <= 1'b0;
      dev_req_valid <= 1'b0;
      dev_req_sel   <= '0;
      dev_req_code  <= '0;
      dev_req_rs1   <= '0;
      dev_req_rs2   <= '0;
      rd_valid      <= 1'b0;
      rd_data       <= '0;
      trap_valid    <= 1'b0;
      trap_target   <= '0;
      dbg_exc       <= 1'b0;
      cmd_done      <= 1'b0;
    end else begin
      rd_valid   <= 1'b0;
      trap_valid <= 1'b0;
      dbg_exc    <= 1'b0;
      cmd_done   <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (cmd_valid) begin
            q_k    <= cmd_k;
            q_rs1  <= cmd_rs1;
            q_rs2  <= cmd_rs2;
            q_priv <= cmd_priv;
            q_dbg  <= cmd_dbg;
            state  <= ST_LOOK;
          end
        end
        ST_LOOK: begin
          if (start_req) begin
            dev_req_valid <= 1'b1;
            dev_req_sel   <= hit_dev;
            dev_req_code  <= {q_k, hit_sub};
            dev_req_rs1   <= q_rs1;
            dev_req_rs2   <= q_rs2;
            state         <= ST_REQ;
          end
        end
        ST_REQ: begin
          if (dev_req_ready) begin
            dev_req_valid <= 1'b0;
            state         <= ST_WAIT;
          end
        end
        default: ;
      endcase
      if (fin_en) begin
        cmd_done <= 1'b1;
        state    <= ST_IDLE;
        if (!fin_fault) begin
          rd_valid <= 1'b1;
          rd_data  <= fin_data;
        end else if (at_mach) begin
          dbg_exc <= q_dbg;
        end else begin
          trap_valid  <= 1'b1;
          trap_target <= flt_target;
        end
      end
    end
  end

  // R8
  busy_after_accept_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_ready) |=> !cmd_ready);

  // R10
  single_result_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({rd_valid, trap_valid, dbg_exc}));

  // R10
  result_with_done_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_valid || trap_valid || dbg_exc) |-> cmd_done);

  // R7
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (dev_req_valid && !dev_req_ready) |=>
      (dev_req_valid && $stable(dev_req_sel) && $stable(dev_req_code) && $stable(dev_req_rs1)));

  // R4
  trap_up_chk: assert property (@(posedge clk) disable iff (rst)
    trap_valid |-> ($onehot(trap_target) && !trap_target[0]));

  // R9
  no_done_while_req_chk: assert property (@(posedge clk) disable iff (rst)
    dev_req_valid |-> !cmd_done);
endmodule

// File: tb/sim_ovl_dispatch.sv
module sim_ovl_dispatch;
  localparam int XLEN = 32;
  localparam int DEPTH = 8;
  localparam int KW = 3;
  localparam int DEVW = 2;
  localparam int IDXW = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic tbl_we = 0, tbl_valid = 0;
  logic [IDXW-1:0] tbl_idx = '0;
  logic [11:0] tbl_lun = '0, tbl_sub = '0;
  logic [3:0] tbl_pmask = '0;
  logic [DEVW-1:0] tbl_dev = '0;
  logic cmd_valid = 0, cmd_dbg = 0;
  logic cmd_ready;
  logic [KW-1:0] cmd_k = '0;
  logic [XLEN-1:0] cmd_rs1 = '0, cmd_rs2 = '0;
  logic [3:0] cmd_priv = 4'b0001;
  logic dev_req_valid, dev_req_ready = 0;
  logic [DEVW-1:0] dev_req_sel;
  logic [14:0] dev_req_code;
  logic [XLEN-1:0] dev_req_rs1, dev_req_rs2;
  logic dev_rsp_valid = 0, dev_rsp_err = 0;
  logic [XLEN-1:0] dev_rsp_data = '0;
  logic rd_valid, trap_valid, dbg_exc, cmd_done;
  logic [XLEN-1:0] rd_data;
  logic [3:0] trap_target;

  ovl_dispatch #(.XLEN(XLEN), .DEPTH(DEPTH), .NDEV(4), .NCMD(8)) u0 (.*);

  int checks = 0;
  int errors = 0;
  bit in_cmd = 0;
  bit finished = 0;

  bit          m_v   [DEPTH];
  logic [11:0] m_lun [DEPTH];
  logic [3:0]  m_pm  [DEPTH];
  logic [1:0]  m_dev [DEPTH];
  logic [11:0] m_sub [DEPTH];

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  // every-cycle monitor: no pulse or request outside a command
  always @(negedge clk) begin
    if (!rst && !in_cmd)
      chk(!(rd_valid || trap_valid || dbg_exc || cmd_done || dev_req_valid), "R10 idle quiet",
          {rd_valid, trap_valid, dbg_exc, cmd_done, dev_req_valid}, 0);
  end

  task automatic wr_entry(input int idx, input bit v, input logic [11:0] lun, input logic [3:0] pm,
                          input logic [1:0] dev, input logic [11:0] sub);
    @(negedge clk);
    tbl_we = 1; tbl_idx = idx[IDXW-1:0]; tbl_valid = v; tbl_lun = lun;
    tbl_pmask = pm; tbl_dev = dev; tbl_sub = sub;
    m_v[idx] = v; m_lun[idx] = lun; m_pm[idx] = pm; m_dev[idx] = dev; m_sub[idx] = sub;
    @(negedge clk);
    tbl_we = 0;
  endtask

  function automatic int m_find(input logic [11:0] lun, input logic [3:0] pr);
    for (int e = 0; e < DEPTH; e++)
      if (m_v[e] && m_lun[e] == lun && (m_pm[e] & pr) != 0) return e;
    return -1;
  endfunction

  task automatic check_outcome(input string req, input bit fault, input logic [XLEN-1:0] val,
                               input logic [3:0] pr, input bit dbg);
    bit ex_rd, ex_tr, ex_dbg;
    logic [3:0] ex_tgt;
    ex_rd = !fault;
    ex_tr = fault && pr != 4'b1000;
    ex_dbg = fault && pr == 4'b1000 && dbg;
    ex_tgt = pr << 1;
    chk(cmd_done == 1, req, cmd_done, 1);
    chk(rd_valid == ex_rd, req, rd_valid, ex_rd);
    if (ex_rd) chk(rd_data == val, req, rd_data, val);
    chk(trap_valid == ex_tr, req, trap_valid, ex_tr);
    if (ex_tr) chk(trap_target == ex_tgt, req, trap_target, ex_tgt);
    chk(dbg_exc == ex_dbg, req, dbg_exc, ex_dbg);
    chk(cmd_ready == 1, "R8 ready at done", cmd_ready, 1);
  endtask

  task automatic run_cmd(input string req, input logic [2:0] k, input logic [XLEN-1:0] rs1,
                         input logic [XLEN-1:0] rs2, input logic [3:0] pr, input bit dbg,
                         input int rdy_wait, input int rsp_wait,
                         input logic [XLEN-1:0] rsp_data, input bit rsp_err);
    logic [11:0] lun;
    int idx;
    bit route;
    lun = rs1[11:0];
    idx = m_find(lun, pr);
    route = (lun > 31) && (idx >= 0);
    @(negedge clk);
    in_cmd = 1;
    chk(cmd_ready == 1, "R8 idle ready", cmd_ready, 1);
    cmd_valid = 1; cmd_k = k; cmd_rs1 = rs1; cmd_rs2 = rs2; cmd_priv = pr; cmd_dbg = dbg;
    @(negedge clk);
    cmd_valid = 0; cmd_dbg = 0;
    chk(cmd_ready == 0, "R8 busy", cmd_ready, 0);
    @(negedge clk);
    if (!route) begin
      chk(dev_req_valid == 0, req, dev_req_valid, 0);
      check_outcome(req, lun != 1 && lun != 2, (lun == 2) ? '1 : '0, pr, dbg);
    end else begin
      chk(dev_req_valid == 1, "R7 req raised", dev_req_valid, 1);
      chk(dev_req_sel == m_dev[idx], "R6 R7 device", dev_req_sel, m_dev[idx]);
      chk(dev_req_code == {k, m_sub[idx]}, "R6 R7 code", dev_req_code, {k, m_sub[idx]});
      chk(dev_req_rs1 == rs1 && dev_req_rs2 == rs2, "R7 operands", dev_req_rs1, rs1);
      chk(cmd_done == 0, "R8 no early done", cmd_done, 0);
      for (int i = 0; i < rdy_wait; i++) begin
        @(negedge clk);
        chk(dev_req_valid == 1 && dev_req_code == {k, m_sub[idx]}, "R7 hold", dev_req_valid, 1);
      end
      dev_req_ready = 1;
      @(negedge clk);
      dev_req_ready = 0;
      chk(dev_req_valid == 0, "R7 drop", dev_req_valid, 0);
      chk(cmd_ready == 0, "R8 busy waiting", cmd_ready, 0);
      for (int i = 0; i < rsp_wait; i++) begin
        @(negedge clk);
        chk(cmd_done == 0 && cmd_ready == 0, "R8 wait", cmd_done, 0);
      end
      dev_rsp_valid = 1; dev_rsp_data = rsp_data; dev_rsp_err = rsp_err;
      @(negedge clk);
      dev_rsp_valid = 0; dev_rsp_err = 0;
      check_outcome(req, rsp_err, rsp_data, pr, dbg);
    end
    @(negedge clk);
    chk(!(cmd_done || rd_valid || trap_valid || dbg_exc), "R10 single pulse", cmd_done, 0);
    in_cmd = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    for (int e = 0; e < DEPTH; e++) m_v[e] = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(cmd_ready == 1, "R1 ready", cmd_ready, 1);
    chk(!(rd_valid || trap_valid || dbg_exc || cmd_done || dev_req_valid), "R1 quiet", 0, 0);

    // R6 before any load: everything above 31 misses and traps
    run_cmd("R1 R4 empty table", 3'd0, 32'h0000_0020, 0, 4'b0001, 0, 0, 0, 0, 0);

    wr_entry(0, 1, 12'd32, 4'b0111, 2'd0, 12'd0);
    wr_entry(1, 1, 12'd32, 4'b1000, 2'd0, 12'd64);
    wr_entry(2, 1, 12'd33, 4'b0011, 2'd1, 12'd1);
    wr_entry(3, 1, 12'd34, 4'b0110, 2'd1, 12'd0);
    wr_entry(4, 1, 12'd33, 4'b0010, 2'd2, 12'd5);
    wr_entry(5, 1, 12'd5,  4'b1111, 2'd2, 12'd7);
    wr_entry(6, 1, 12'd1,  4'b1111, 2'd3, 12'd9);
    wr_entry(7, 1, 12'd2,  4'b1111, 2'd3, 12'd9);

    run_cmd("R2 zero user",      3'd3, 32'hABCD_E001, 32'h1234, 4'b0001, 0, 0, 0, 0, 0);
    run_cmd("R2 zero machine",   3'd7, 32'h0000_0001, 32'h0,    4'b1000, 1, 0, 0, 0, 0);
    run_cmd("R3 ones machine",   3'd0, 32'h0000_0002, 32'h5,    4'b1000, 0, 0, 0, 0, 0);
    run_cmd("R3 ones hyper",     3'd5, 32'hFFFF_F002, 32'h5,    4'b0100, 0, 0, 0, 0, 0);
    run_cmd("R4 unit0 user",     3'd1, 32'h0000_0000, 0,        4'b0001, 0, 0, 0, 0, 0);
    run_cmd("R4 unit0 hyper",    3'd1, 32'h0000_0000, 0,        4'b0100, 0, 0, 0, 0, 0);
    run_cmd("R4 reserved unit5", 3'd2, 32'h0000_0005, 0,        4'b0010, 0, 0, 0, 0, 0);
    run_cmd("R4 R6 priv miss",   3'd2, 32'h0000_0022, 0,        4'b0001, 0, 0, 0, 0, 0);
    run_cmd("R5 mach dbg",       3'd0, 32'h0000_0000, 0,        4'b1000, 1, 0, 0, 0, 0);
    run_cmd("R5 mach silent",    3'd0, 32'h0000_0000, 0,        4'b1000, 0, 0, 0, 0, 0);
    run_cmd("R9 route super",    3'd5, 32'h7700_0020, 32'hCAFE, 4'b0010, 0, 2, 3, 32'hDEAD_BEEF, 0);
    run_cmd("R9 route mach sub", 3'd2, 32'h0000_0020, 32'h1,    4'b1000, 0, 0, 0, 32'h0000_0042, 0);
    run_cmd("R6 lowest index",   3'd4, 32'h0000_0021, 32'h2,    4'b0010, 0, 1, 0, 32'h0000_1111, 0);
    run_cmd("R9 cfg err trap",   3'd1, 32'h0000_0022, 32'h3,    4'b0100, 0, 0, 1, 32'h5555_5555, 1);
    run_cmd("R9 R5 cfg err mach", 3'd6, 32'h0000_0020, 32'h3,   4'b1000, 1, 0, 2, 32'h0, 1);

    // R6 invalidate entry 2: lun 33 at supervisor now falls to entry 4
    wr_entry(2, 0, 12'd33, 4'b0011, 2'd1, 12'd1);
    run_cmd("R6 after invalidate", 3'd0, 32'h0000_0021, 32'h9,  4'b0010, 0, 0, 0, 32'h0000_2222, 0);
    run_cmd("R4 R6 user miss",     3'd0, 32'h0000_0021, 32'h9,  4'b0001, 0, 0, 0, 0, 0);

    repeat (3) @(negedge clk);
    summary();
  end
endmodule